// File: doc/BRIEF.md
# Multi-Period Reciprocal Frequency Counter

This block measures how long a slow input signal takes to complete a chosen number of periods, in cycles of a fast reference clock. A 16-bit timebase runs freely on the reference clock. A second counter extends it to a 32-bit timestamp by counting the times it rolls over. The measured signal is synchronized into the reference domain. Each of its rising edges takes a timestamp in hardware, so no software read latency enters the measurement.

Software pulses `start` with a period count N on `n_periods`. The next rising edge of the input opens the sequence and stores its timestamp. N further rising edges then decrement an internal counter. At the last of them the block reports the difference between the closing and opening timestamps on `span`. It raises `span_valid` for one cycle and drops `busy`. Converting the count into a frequency is left to the user: the frequency is N times the reference frequency divided by the count.

Top module: `freq_recip_counter`

## Requirements
- R1: After reset `busy`, `span_valid` and `span` are all zero.
- R2: For an input with a period of P reference cycles and a setting of N = 32, `span` equals 32·P. This is the count of reference cycles from the opening rising edge to the 32nd rising edge after it.
- R3: The setting N = 40 is accepted, and `span` stays exact (N·P) when the sequence crosses one or more rollovers of the 16-bit timebase.
- R4: N is sampled on the accepted `start` pulse. A setting of 0 behaves as 1.
- R5: `busy` is 1 from the cycle after an accepted `start` until the result cycle. `span_valid` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R6: A `start` pulse while `busy` is 1 is ignored. The running sequence keeps its original N and `busy` stays 1.
- R7: `span` keeps its value between results.
- R8: The 32-bit extended timestamp advances by exactly one per reference cycle, including the cycle in which the 16-bit timebase rolls over. A capture in that cycle sees the rollover already applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Measured signal (asynchronous) |
| start | input | 1 | One-cycle request to begin a sequence |
| n_periods | input | 8 | Number of input periods to span (0 treated as 1) |
| span | output | 32 | Reference cycles between the opening and closing edges |
| span_valid | output | 1 | One-cycle pulse when `span` is updated |
| busy | output | 1 | A sequence is armed or running |

## Verification
The hardest case to reach from the ports is a sequence whose two timestamps sit on opposite sides of a timebase rollover. That takes more than 65,536 reference cycles of a single measurement. The bench runs N = 40 with an input period of 2,000 cycles, which spans 80,000 cycles and must cross at least one rollover, and then checks the exact product. The one-per-cycle rule for the extended timestamp, including the rollover cycle itself, is guarded inside the timebase. The ignored-start case is reached by pulsing `start` with a different N in the middle of a running sequence.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } frc_state_e;
endpackage

// File: rtl/frc_timebase.sv
module frc_timebase #(
  parameter int TS_W  = 16,
  parameter int EXT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [EXT_W-1:0] ts_cap
);
  localparam int WR_W = EXT_W - TS_W;

  logic [TS_W-1:0] tb_q;
  logic [WR_W-1:0] wr_q;
  logic [TS_W-1:0] tb_d;
  logic [WR_W-1:0] wr_d;
  logic            wrap_evt;
  logic [EXT_W-1:0] ts_now;

  function automatic logic [WR_W-1:0] next_wraps(input logic [WR_W-1:0] w, input logic roll);
    return roll ? w + 1'b1 : w;
  endfunction

  assign wrap_evt = &tb_q;
  assign tb_d     = tb_q + 1'b1;
  assign wr_d     = next_wraps(wr_q, wrap_evt);
  assign ts_now   = {wr_q, tb_q};
  // rollover applied before the capture sees it
  assign ts_cap   = {wr_d, tb_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
      wr_q <= '0;
    end else begin
      tb_q <= tb_d;
      wr_q <= wr_d;
    end
  end

  p_ext_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_now == $past(ts_now) + 1'b1);
  p_wrap_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (tb_q == '0) && (wr_q == $past(wr_q) + 1'b1));
endmodule

// File: rtl/frc_edge.sv
module frc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise_evt
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], sig_in};
  end

  assign rise_evt = sh_q[SH_W-2] & ~sh_q[SH_W-1];

  p_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
endmodule

// File: rtl/frc_seq.sv
module frc_seq
  import frc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int EXT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_periods,
  input  logic             edge_evt,
  input  logic [EXT_W-1:0] ts_cap,
  output logic [EXT_W-1:0] span,
  output logic             span_valid,
  output logic             busy
);
  frc_state_e       state_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] left_q;
  logic [EXT_W-1:0] first_q;
  logic             accept_evt;
  logic             open_evt;
  logic             close_evt;

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] n);
    return (n == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : n;
  endfunction

  function automatic logic [EXT_W-1:0] span_of(input logic [EXT_W-1:0] last,
                                               input logic [EXT_W-1:0] first);
    return last - first;
  endfunction

  assign accept_evt = (state_q == ST_IDLE) && start;
  assign open_evt   = (state_q == ST_ARM) && edge_evt;
  assign close_evt  = (state_q == ST_RUN) && edge_evt && (left_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      n_q        <= '0;
      left_q     <= '0;
      first_q    <= '0;
      span       <= '0;
      span_valid <= 1'b0;
    end else begin
      span_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept_evt) begin
          n_q     <= n_periods;
          state_q <= ST_ARM;
        end
        ST_ARM: if (open_evt) begin
          first_q <= ts_cap;
          left_q  <= eff_count(n_q);
          state_q <= ST_RUN;
        end
        ST_RUN: if (close_evt) begin
          span       <= span_of(ts_cap, first_q);
          span_valid <= 1'b1;
          state_q    <= ST_IDLE;
        end else if (edge_evt) begin
          left_q <= left_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid |=> !span_valid);
  p_idle_on_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid |-> !busy);
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_q));
  p_run_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (left_q != '0));
  p_hold_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !span_valid |-> $stable(span));
  p_close_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> span_valid);
endmodule

// File: rtl/freq_recip_counter.sv
module freq_recip_counter #(
  parameter int TS_W        = 16,
  parameter int EXT_W       = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             start,
  input  logic [CNT_W-1:0] n_periods,
  output logic [EXT_W-1:0] span,
  output logic             span_valid,
  output logic             busy
);
  logic [EXT_W-1:0] ts_cap;
  logic             rise_evt;

  frc_timebase #(.TS_W(TS_W), .EXT_W(EXT_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_cap (ts_cap)
  );

  frc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (sig_in),
    .rise_evt (rise_evt)
  );

  frc_seq #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .n_periods  (n_periods),
    .edge_evt   (rise_evt),
    .ts_cap     (ts_cap),
    .span       (span),
    .span_valid (span_valid),
    .busy       (busy)
  );

  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

// File: tb/freq_recip_counter_test.sv
module freq_recip_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  n_periods = 8'd0;
  logic [31:0] span;
  logic        span_valid;
  logic        busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int per = 10;
  int phase = 0;

  freq_recip_counter uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
    .n_periods(n_periods), .span(span), .span_valid(span_valid), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, act=%0d exp=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // input waveform, period per reference cycles, changes away from edges
  always @(negedge clk) begin
    phase  <= (phase + 1 >= per) ? 0 : phase + 1;
    sig_in <= (phase < per / 2);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_period(input int p);
    @(negedge clk);
    per   = p;
    phase = 0;
  endtask

  task automatic pulse_start(input logic [7:0] n);
    @(negedge clk);
    n_periods = n;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_result(input int limit, output logic got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (span_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input string req, input logic [7:0] n, input int p, input int exp_mult);
    logic got;
    set_period(p);
    pulse_start(n);
    chk({req, " busy after start"}, busy, 1'b1);
    wait_result((exp_mult + 3) * p + 20, got);
    chk({req, " result arrived"}, got, 1'b1);
    chk({req, " span"}, span, exp_mult * p);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 1'b0);
    chk("R1 valid", span_valid, 1'b0);
    chk("R1 span", span, 32'd0);
  endtask

  task automatic t_default32;
    measure("R2 N=32", 8'd32, 50, 32);
    chk("R5 busy low on result", busy, 1'b0);
    @(negedge clk);
    chk("R5 valid one cycle", span_valid, 1'b0);
    repeat (120) @(negedge clk);
    chk("R7 span held", span, 32'd1600);
  endtask

  task automatic t_wrap40;
    // 40 * 2000 = 80000 cycles, crosses the 16-bit rollover (R8 path)
    measure("R3 N=40 across wrap", 8'd40, 2000, 40);
  endtask

  task automatic t_small;
    measure("R4 N=1", 8'd1, 37, 1);
    measure("R2 N=3 short period", 8'd3, 7, 3);
    measure("R4 N=0 as 1", 8'd0, 37, 1);
  endtask

  task automatic t_ignore;
    logic got;
    set_period(100);
    pulse_start(8'd4);
    repeat (150) @(negedge clk);
    pulse_start(8'd9);
    chk("R6 busy kept", busy, 1'b1);
    wait_result(1000, got);
    chk("R6 result arrived", got, 1'b1);
    chk("R6 original N kept", span, 32'd400);
    @(negedge clk);
    chk("R6 idle after result", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_default32();
    t_small();
    t_ignore();
    t_wrap40();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule